// File: doc/BRIEF.md
# Instrument Status and Service-Request Unit

This block keeps the status reporting state of a programmable power source and decides when the instrument asks its controller for attention. It has three status groups: questionable conditions, operation conditions and standard events. Each group latches rising edges of its condition inputs into an event register. Each group has its own enable mask, and it reduces the enabled, latched events to one summary bit.

The summary bits, together with a message-available flag taken from the output queue occupancy, make up an 8-bit status byte. A service-request enable mask selects which status byte bits may raise a request. A rising edge of the masked OR sets the request-for-service flag, which drives the `srq` line. A serial-poll strobe returns the status byte with the request flag in bit 6 and then clears only that flag.

Software reaches the registers through a small port with an address, a write enable and a read strobe. Reading an event register clears it, and so removes its share of the summary.

Top module: `svc_status_unit`

## Requirements
- R1: A group event bit is set on the clock edge at which its condition input is 1 and was 0 on the previous edge. It stays set until the event register is read. A new edge in the same cycle as that read leaves the new bit set afterwards.
- R2: A read of an event register (address 0 questionable, 2 operation, 4 standard) returns its contents and clears it on that clock edge. Reads of the enable registers (addresses 1, 3, 5), the status byte (6) and the request mask (7) change nothing.
- R3: Status byte bit 3 is the OR of questionable events AND questionable enable. Bit 5 is the same reduction for the standard group, and bit 7 is the same for the operation group. Bits 0 to 2 read 0.
- R4: Status byte bit 4 equals the queue-nonempty input in the same cycle.
- R5: The request flag is set on the edge after the master summary rises. The master summary is the OR of (status byte AND request mask) with bit 6 excluded. Bit 6 of a written request mask is dropped and reads back 0. `srq` equals the request flag.
- R6: A serial poll returns the status byte with the request flag in bit 6 on `pollData`. The following edge clears the request flag and leaves every other status byte bit unchanged.
- R7: Once a group enable bit or a request mask bit is cleared, events latched or raised in that path raise no new request.
- R8: After reset, all event, enable and mask registers read 0 and `srq` is 0.
- R9: With questionable enable 11 and request mask 8, only questionable bits 0, 1 and 3 (overvoltage, overcurrent, overtemperature) raise `srq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| quesCond | input | GRP_W | Questionable condition inputs |
| operCond | input | GRP_W | Operation condition inputs |
| stdCond | input | GRP_W | Standard event condition inputs |
| queueNotEmpty | input | 1 | Output queue holds at least one byte |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write enable |
| regRdEn | input | 1 | Register read strobe (clears event registers) |
| regWrData | input | GRP_W | Register write data |
| regRdData | output | GRP_W | Register read data for the addressed register |
| pollStrobe | input | 1 | Serial poll strobe |
| pollData | output | 8 | Serial poll response byte |
| srq | output | 1 | Service request line |

## Verification
The bench sweeps each of the 16 questionable bits under the 11/8 programming. A design with a misplaced summary bit or a wrong mask width would request service on the wrong faults. All 256 request-mask values are then applied against a fixed status byte. A design that honoured bit 6 or mapped a summary to the wrong position would assert `srq` where the arithmetic says it must not.

Directed cases cover three further faults. An edge that arrives in the same cycle as a clearing read would be lost by a design that lets the clear win. A poll that wiped MAV or the summaries would show a changed status byte on the second poll. A design that kept raising requests from a disabled path would assert `srq` after its mask bit was cleared.

// File: rtl/svc_status_pkg.sv
package svc_status_pkg;

  localparam int STB_W  = 8;
  localparam int ADDR_W = 3;

  localparam int BIT_QUES = 3;
  localparam int BIT_MAV  = 4;
  localparam int BIT_ESB  = 5;
  localparam int BIT_RQS  = 6;
  localparam int BIT_OPER = 7;

  localparam int NUM_GRP  = 3;
  localparam int GRP_QUES = 0;
  localparam int GRP_OPER = 1;
  localparam int GRP_STD  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_QUES_EVT = 3'd0,
    ADR_QUES_EN  = 3'd1,
    ADR_OPER_EVT = 3'd2,
    ADR_OPER_EN  = 3'd3,
    ADR_STD_EVT  = 3'd4,
    ADR_STD_EN   = 3'd5,
    ADR_STB      = 3'd6,
    ADR_SRE      = 3'd7
  } regSel_e;

  typedef struct packed {
    logic [NUM_GRP-1:0] wrEn;
    logic [NUM_GRP-1:0] clrEvt;
    logic               wrSre;
  } ctlStrobes_t;

endpackage

// File: rtl/svc_event_group.sv
module svc_event_group #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] cond,
  input  logic         clrEvt,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] evt,
  output logic [W-1:0] en,
  output logic         summary
);

  logic [W-1:0] condQ;
  logic [W-1:0] risen;

  assign risen   = cond & ~condQ;
  assign summary = |(evt & en);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ <= '0;
      evt   <= '0;
      en    <= '0;
    end else begin
      condQ <= cond;
      evt   <= (clrEvt ? '0 : evt) | risen;
      if (wrEn) en <= wrData;
    end
  end

  // R1: latched bits survive any cycle without a clearing read
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !clrEvt |=> ((evt & $past(evt)) == $past(evt)));

  // R1: a fresh edge is kept even when a read clears the register
  a_r1_edge_kept: assert property (@(posedge clk) disable iff (!rstN)
    (|risen) |=> ((evt & $past(risen)) == $past(risen)));

  // R2: a read with no fresh edge empties the register
  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrEvt && !(|risen)) |=> (evt == '0));

endmodule

// File: rtl/svc_status_datapath.sv
module svc_status_datapath
  import svc_status_pkg::*;
#(
  parameter int GRP_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [GRP_W-1:0]       quesCond,
  input  logic [GRP_W-1:0]       operCond,
  input  logic [GRP_W-1:0]       stdCond,
  input  logic                   queueNotEmpty,
  input  ctlStrobes_t            strb,
  input  logic [GRP_W-1:0]       wrData,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   rqs,
  output logic [STB_W-1:0]       stbFull,
  output logic                   masterSum,
  output logic [GRP_W-1:0]       rdData
);

  localparam logic [STB_W-1:0] RQS_MASK = STB_W'(1) << BIT_RQS;

  logic [GRP_W-1:0] condArr [NUM_GRP];
  logic [GRP_W-1:0] evtArr  [NUM_GRP];
  logic [GRP_W-1:0] enArr   [NUM_GRP];
  logic [NUM_GRP-1:0] sumVec;
  logic [STB_W-1:0] sre;
  logic [STB_W-1:0] stbCore;

  assign condArr[GRP_QUES] = quesCond;
  assign condArr[GRP_OPER] = operCond;
  assign condArr[GRP_STD]  = stdCond;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGroup
    svc_event_group #(.W(GRP_W)) u_grp (
      .clk     (clk),
      .rstN    (rstN),
      .cond    (condArr[g]),
      .clrEvt  (strb.clrEvt[g]),
      .wrEn    (strb.wrEn[g]),
      .wrData  (wrData),
      .evt     (evtArr[g]),
      .en      (enArr[g]),
      .summary (sumVec[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sre <= '0;
    else if (strb.wrSre) sre <= wrData[STB_W-1:0] & ~RQS_MASK;
  end

  always_comb begin
    stbCore           = '0;
    stbCore[BIT_QUES] = sumVec[GRP_QUES];
    stbCore[BIT_MAV]  = queueNotEmpty;
    stbCore[BIT_ESB]  = sumVec[GRP_STD];
    stbCore[BIT_OPER] = sumVec[GRP_OPER];
  end

  assign masterSum = |(stbCore & sre & ~RQS_MASK);

  always_comb begin
    stbFull          = stbCore;
    stbFull[BIT_RQS] = rqs;
  end

  always_comb begin
    rdData = '0;
    unique case (regSel_e'(regAddr))
      ADR_QUES_EVT: rdData = evtArr[GRP_QUES];
      ADR_QUES_EN:  rdData = enArr[GRP_QUES];
      ADR_OPER_EVT: rdData = evtArr[GRP_OPER];
      ADR_OPER_EN:  rdData = enArr[GRP_OPER];
      ADR_STD_EVT:  rdData = evtArr[GRP_STD];
      ADR_STD_EN:   rdData = enArr[GRP_STD];
      ADR_STB:      rdData = GRP_W'(stbFull);
      ADR_SRE:      rdData = GRP_W'(sre);
      default:      rdData = '0;
    endcase
  end

  // R5: the request mask never holds bit 6
  a_r5_sre_bit6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSre |=> !sre[BIT_RQS]);

  // R7: with an empty request mask, the master summary stays low
  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (sre == '0) |-> !masterSum);

endmodule

// File: rtl/svc_status_control.sv
module svc_status_control
  import svc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              pollStrobe,
  input  logic              masterSum,
  output ctlStrobes_t       strb,
  output logic              rqs
);

  logic masterSumQ;
  logic reqRise;

  always_comb begin
    strb = '0;
    strb.wrEn[GRP_QUES]   = regWrEn && (regSel_e'(regAddr) == ADR_QUES_EN);
    strb.wrEn[GRP_OPER]   = regWrEn && (regSel_e'(regAddr) == ADR_OPER_EN);
    strb.wrEn[GRP_STD]    = regWrEn && (regSel_e'(regAddr) == ADR_STD_EN);
    strb.clrEvt[GRP_QUES] = regRdEn && (regSel_e'(regAddr) == ADR_QUES_EVT);
    strb.clrEvt[GRP_OPER] = regRdEn && (regSel_e'(regAddr) == ADR_OPER_EVT);
    strb.clrEvt[GRP_STD]  = regRdEn && (regSel_e'(regAddr) == ADR_STD_EVT);
    strb.wrSre            = regWrEn && (regSel_e'(regAddr) == ADR_SRE);
  end

  assign reqRise = masterSum && !masterSumQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterSumQ <= 1'b0;
      rqs        <= 1'b0;
    end else begin
      masterSumQ <= masterSum;
      rqs        <= reqRise | (rqs & ~pollStrobe);
    end
  end

  // R6: a poll without a fresh request leaves the flag clear
  a_r6_poll_clears: assert property (@(posedge clk) disable iff (!rstN)
    (pollStrobe && !reqRise) |=> !rqs);

  // R5: the flag only rises after a rising master summary
  a_r5_rise_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rqs) |-> $past(reqRise));

  // R7: no master summary means no new request
  a_r7_no_new_req: assert property (@(posedge clk) disable iff (!rstN)
    !masterSum |=> !$rose(rqs));

endmodule

// File: rtl/svc_status_unit.sv
module svc_status_unit
  import svc_status_pkg::*;
#(
  parameter int GRP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [GRP_W-1:0]  quesCond,
  input  logic [GRP_W-1:0]  operCond,
  input  logic [GRP_W-1:0]  stdCond,
  input  logic              queueNotEmpty,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [GRP_W-1:0]  regWrData,
  output logic [GRP_W-1:0]  regRdData,
  input  logic              pollStrobe,
  output logic [STB_W-1:0]  pollData,
  output logic              srq
);

  ctlStrobes_t      strb;
  logic             rqs;
  logic             masterSum;
  logic [STB_W-1:0] stbFull;

  svc_status_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .pollStrobe (pollStrobe),
    .masterSum  (masterSum),
    .strb       (strb),
    .rqs        (rqs)
  );

  svc_status_datapath #(.GRP_W(GRP_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .quesCond      (quesCond),
    .operCond      (operCond),
    .stdCond       (stdCond),
    .queueNotEmpty (queueNotEmpty),
    .strb          (strb),
    .wrData        (regWrData),
    .regAddr       (regAddr),
    .rqs           (rqs),
    .stbFull       (stbFull),
    .masterSum     (masterSum),
    .rdData        (regRdData)
  );

  assign pollData = stbFull;
  assign srq      = rqs;

  // R6: after a poll, the non-request bits of the byte hold while inputs hold
  a_r6_poll_keeps_rest: assert property (@(posedge clk) disable iff (!rstN)
    (pollStrobe && !regRdEn && !regWrEn && $stable(queueNotEmpty)) |=>
      ((pollData & 8'hBF) == ($past(pollData) & 8'hBF)) || $changed(quesCond)
      || $changed(operCond) || $changed(stdCond) || $changed(queueNotEmpty));

endmodule

// File: tb/svc_status_unit_tb.sv
module svc_status_unit_tb;

  localparam int GW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [GW-1:0] quesCond = '0;
  logic [GW-1:0] operCond = '0;
  logic [GW-1:0] stdCond = '0;
  logic          queueNotEmpty = 1'b0;
  logic [2:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [GW-1:0] regWrData = '0;
  logic [GW-1:0] regRdData;
  logic          pollStrobe = 1'b0;
  logic [7:0]    pollData;
  logic          srq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  svc_status_unit #(.GRP_W(GW)) u_dut (
    .clk(clk), .rstN(rstN), .quesCond(quesCond), .operCond(operCond),
    .stdCond(stdCond), .queueNotEmpty(queueNotEmpty), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .pollStrobe(pollStrobe), .pollData(pollData),
    .srq(srq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [GW-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [GW-1:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic doPoll(output logic [7:0] d);
    pollStrobe = 1'b1;
    #1 d = pollData;
    @(negedge clk);
    pollStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [GW-1:0] rd;
    logic [7:0] pd;
    logic [7:0] stbExp;
    logic expSrq;

    idle(2);
    rstN = 1'b1;
    idle(1);

    // R8: reset state of every register and the line
    for (int a = 0; a < 8; a++) begin
      doRead(3'(a), rd);
      check("R8 reset read", 32'(rd), 32'h0);
    end
    check("R8 srq after reset", 32'(srq), 32'h0);

    // R4: MAV tracks queue occupancy
    queueNotEmpty = 1'b1;
    doRead(3'd6, rd);
    check("R4 MAV set", 32'(rd), 32'h10);
    queueNotEmpty = 1'b0;
    doRead(3'd6, rd);
    check("R4 MAV clear", 32'(rd), 32'h00);

    // R9/R3: sweep every questionable bit with enable 11 and mask 8
    doWrite(3'd1, 16'd11);
    doWrite(3'd7, 16'd8);
    for (int i = 0; i < GW; i++) begin
      expSrq = (i == 0) || (i == 1) || (i == 3);
      quesCond = GW'(1) << i;
      idle(1);
      doRead(3'd6, rd);
      check("R3 QUES summary bit", 32'(rd), expSrq ? 32'h08 : 32'h00);
      check("R9 srq for ques bit", 32'(srq), 32'(expSrq));
      quesCond = '0;
      doRead(3'd0, rd);
      check("R2 event read value", 32'(rd), 32'(GW'(1) << i));
      doRead(3'd0, rd);
      check("R2 event cleared", 32'(rd), 32'h0);
      doPoll(pd);
      check("R6 poll rqs bit", 32'(pd), expSrq ? 32'h40 : 32'h00);
      check("R6 srq cleared", 32'(srq), 32'h0);
    end

    // R1: edge arriving together with a clearing read is kept
    quesCond = 16'h0002;
    idle(2);
    quesCond = 16'h0003;
    doRead(3'd0, rd);
    check("R1 read before same-cycle edge", 32'(rd), 32'h2);
    doRead(3'd0, rd);
    check("R1 same-cycle edge kept", 32'(rd), 32'h1);
    idle(2);
    doRead(3'd0, rd);
    check("R1 held level makes no new event", 32'(rd), 32'h0);
    quesCond = '0;
    doPoll(pd);
    idle(1);

    // R2: enable reads are not destructive
    doRead(3'd1, rd);
    check("R2 enable readback", 32'(rd), 32'd11);
    doRead(3'd1, rd);
    check("R2 enable readback again", 32'(rd), 32'd11);

    // R5/R3: latch all groups, fixed status byte 0xB8, sweep all masks
    doWrite(3'd7, 16'h0);
    doWrite(3'd1, 16'hFFFF);
    doWrite(3'd3, 16'hFFFF);
    doWrite(3'd5, 16'hFFFF);
    quesCond = 16'h8000; operCond = 16'h0100; stdCond = 16'h0004;
    queueNotEmpty = 1'b1;
    idle(1);
    doRead(3'd6, rd);
    check("R3 full status byte", 32'(rd), 32'hB8);
    for (int v = 0; v < 256; v++) begin
      doWrite(3'd7, 16'h0);
      doPoll(pd);
      doWrite(3'd7, GW'(v));
      idle(1);
      expSrq = |(8'hB8 & 8'(v) & 8'hBF);
      check("R5 srq for mask", 32'(srq), 32'(expSrq));
      doRead(3'd7, rd);
      check("R5 mask readback", 32'(rd), 32'(8'(v) & 8'hBF));
    end

    // R6: poll clears only RQS
    doWrite(3'd7, 16'h0);
    doPoll(pd);
    doWrite(3'd7, 16'h80);
    idle(1);
    doPoll(pd);
    check("R6 poll with request", 32'(pd), 32'hF8);
    doPoll(pd);
    check("R6 rest of byte kept", 32'(pd), 32'hB8);
    check("R6 srq low", 32'(srq), 32'h0);

    // R7: disabling the group enable blocks a new event
    doRead(3'd0, rd);
    doRead(3'd2, rd);
    doRead(3'd4, rd);
    queueNotEmpty = 1'b0;
    quesCond = '0; operCond = '0; stdCond = '0;
    doWrite(3'd7, 16'h08);
    doWrite(3'd1, 16'h0);
    idle(1);
    quesCond = 16'h0001;
    idle(3);
    check("R7 group enable off", 32'(srq), 32'h0);
    doRead(3'd0, rd);
    check("R7 event still latched", 32'(rd), 32'h1);
    // R7: clearing the request mask bit blocks the operation path
    doWrite(3'd7, 16'h0);
    operCond = 16'h0001;
    idle(3);
    check("R7 mask off", 32'(srq), 32'h0);
    doRead(3'd6, rd);
    stbExp = 8'h80;
    check("R7 oper summary still set", 32'(rd), 32'(stbExp));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule